// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the memory operand address for a CPU with 32-bit address registers and a 24-bit external address space. It covers two families of operand addressing. The first uses an address register that is stepped by the operand size: post-increment, where the old register value is the address, and pre-decrement, where the stepped value is both the address and the new register value. The second takes an absolute address field of 8, 16, 24 or 32 bits from the instruction and widens it by a rule that depends on the field's width.

Decode presents a mode, an operand size, a program-fetch flag, the selected register value and the immediate field, qualified by a valid strobe. One clock later the unit returns the 24-bit effective address, the 32-bit register write-back value with its enable, an alignment fault flag and an illegal-combination flag. The register file, the decoder and the bus interface sit outside the block.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, valid_o, ea_o, wb_val_o, wb_en_o, align_fault_o and illegal_o are all zero.
- R2: Outputs are registered with one cycle of latency: valid_o equals valid_i of the previous cycle; after a cycle with valid_i low, valid_o, wb_en_o, align_fault_o and illegal_o are 0 while ea_o and wb_val_o keep their previous values.
- R3: Mode 0 (post-increment): ea_o is the low 24 bits of the unmodified register value, and wb_val_o is the register value plus the step, wrapping modulo 2^32.
- R4: Mode 1 (pre-decrement): wb_val_o is the register value minus the step, wrapping modulo 2^32, and ea_o is the low 24 bits of that same difference.
- R5: The step is given by size_i: 0 is a byte (step 1), 1 a word (step 2), 2 a longword (step 4); size 3 in modes 0 and 1 is an illegal combination.
- R6: In modes 0 and 1, a word or longword access with an odd register value raises align_fault_o and clears wb_en_o; ea_o and wb_val_o still carry the computed values. A byte access never faults.
- R7: wb_en_o is 1 only for a legal, non-faulting access in mode 0 or 1; in every absolute mode it is 0 and wb_val_o is 0. In modes 0 and 1 the program-fetch flag has no effect.
- R8: Mode 2 (8-bit absolute, data only): ea_o is 0xFFFF00 with the low 8 field bits in its low byte.
- R9: Mode 3 (16-bit absolute, data only): the low 16 field bits are sign-extended, reaching 0x000000 to 0x007FFF and 0xFF8000 to 0xFFFFFF.
- R10: Mode 4 (24-bit absolute, program fetch only): the upper 8 bits of the field are forced to zero and ea_o is field bits 23:0.
- R11: Mode 5 (32-bit absolute, data only): the field is used unmodified and ea_o is its low 24 bits.
- R12: illegal_o is set for mode 4 with fetch_i low, modes 2, 3 or 5 with fetch_i high, modes 6 and 7, and size 3 in modes 0 and 1; an illegal access gives ea_o 0, wb_val_o 0, wb_en_o 0 and align_fault_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request qualifier |
| mode_i | input | 3 | Addressing mode code (0..5, 6 and 7 illegal) |
| size_i | input | 2 | Operand size code (0 byte, 1 word, 2 longword, 3 illegal) |
| fetch_i | input | 1 | 1 for a program-instruction address, 0 for data |
| areg_i | input | 32 | Selected address register value |
| absf_i | input | 32 | Absolute address field from the instruction |
| valid_o | output | 1 | Result valid |
| ea_o | output | 24 | Effective address |
| wb_val_o | output | 32 | Register write-back value |
| wb_en_o | output | 1 | Register write-back enable |
| align_fault_o | output | 1 | Odd register value on a word or longword access |
| illegal_o | output | 1 | Illegal mode, size or fetch combination |

## Verification
The bench aims at the ordering difference between the two stepping modes: a design that swapped them would present the stepped value as the address in post-increment or the old value in pre-decrement, and register values near zero and near 0xFFFFFFFF expose any missing wraparound. It probes the 16-bit sign boundary at 0x7FFF/0x8000 with junk in the unused field bits, where a zero-extending or unmasked design returns the wrong page, and 8-bit fields, where a missing ones fill lands in page zero. Odd register values with byte, word and longword sizes catch a fault that fires on bytes or a write-back that leaks through a fault, and every illegal fetch/width pairing is driven to catch a design that lets a stray address or write-back escape.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    EAM_POSTINC = 3'd0,
    EAM_PREDEC  = 3'd1,
    EAM_ABS8    = 3'd2,
    EAM_ABS16   = 3'd3,
    EAM_ABS24   = 3'd4,
    EAM_ABS32   = 3'd5,
    EAM_RSV6    = 3'd6,
    EAM_RSV7    = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    EAS_BYTE = 2'd0,
    EAS_WORD = 2'd1,
    EAS_LONG = 2'd2,
    EAS_RSV  = 2'd3
  } ea_size_e;

  // Step magnitude for a size code; zero for the reserved code.
  function automatic logic [2:0] size_step(ea_size_e s);
    case (s)
      EAS_BYTE: return 3'd1;
      EAS_WORD: return 3'd2;
      EAS_LONG: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  // True when the mode selects one of the register-stepping forms.
  function automatic logic is_step_mode(ea_mode_e m);
    return (m == EAM_POSTINC) || (m == EAM_PREDEC);
  endfunction

  // True when the mode selects one of the absolute-field forms.
  function automatic logic is_abs_mode(ea_mode_e m);
    return (m == EAM_ABS8) || (m == EAM_ABS16) ||
           (m == EAM_ABS24) || (m == EAM_ABS32);
  endfunction

endpackage

// File: rtl/ea_step_path.sv
module ea_step_path
  import ea_pkg::*;
#(
  parameter int RW  = 32,
  parameter int EAW = 24
) (
  input  ea_mode_e          mode,
  input  ea_size_e          size,
  input  logic [RW-1:0]     areg,
  output logic              step_sel,
  output logic [EAW-1:0]    step_addr,
  output logic [RW-1:0]     step_wb,
  output logic              misalign,
  output logic              size_bad
);

  logic [RW-1:0] step_amt;
  logic [RW-1:0] inc_val;
  logic [RW-1:0] dec_val;
  logic          pre_sel;
  logic          multi_byte;

  assign step_amt   = {{(RW-3){1'b0}}, size_step(size)};
  assign inc_val    = areg + step_amt;
  assign dec_val    = areg - step_amt;
  assign step_sel   = is_step_mode(mode);
  assign pre_sel    = (mode == EAM_PREDEC);
  assign multi_byte = (size == EAS_WORD) || (size == EAS_LONG);

  // Post-increment addresses with the old value; pre-decrement with the new.
  always_comb begin
    if (pre_sel) begin
      step_addr = dec_val[EAW-1:0];
      step_wb   = dec_val;
    end else begin
      step_addr = areg[EAW-1:0];
      step_wb   = inc_val;
    end
  end

  assign misalign = step_sel && multi_byte && areg[0];
  assign size_bad = step_sel && (size == EAS_RSV);

endmodule

// File: rtl/ea_abs_path.sv
module ea_abs_path
  import ea_pkg::*;
#(
  parameter int RW  = 32,
  parameter int EAW = 24
) (
  input  ea_mode_e      mode,
  input  logic          fetch,
  input  logic [RW-1:0] field,
  output logic          abs_sel,
  output logic [RW-1:0] abs_addr,
  output logic          width_bad
);

  localparam int SHORT_W = 8;
  localparam int MID_W   = 16;

  assign abs_sel = is_abs_mode(mode);

  always_comb begin
    case (mode)
      EAM_ABS8:  abs_addr = {{(RW-SHORT_W){1'b1}}, field[SHORT_W-1:0]};
      EAM_ABS16: abs_addr = {{(RW-MID_W){field[MID_W-1]}}, field[MID_W-1:0]};
      EAM_ABS24: abs_addr = {{(RW-EAW){1'b0}}, field[EAW-1:0]};
      EAM_ABS32: abs_addr = field;
      default:   abs_addr = '0;
    endcase
  end

  // The 24-bit form addresses program code only; the others address data only.
  assign width_bad = abs_sel && ((mode == EAM_ABS24) ? !fetch : fetch);

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int RW  = 32,
  parameter int EAW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_c,
  input  logic [EAW-1:0] ea_c,
  input  logic [RW-1:0]  wb_c,
  input  logic           wb_en_c,
  input  logic           fault_c,
  input  logic           illegal_c,
  output logic           valid_o,
  output logic [EAW-1:0] ea_o,
  output logic [RW-1:0]  wb_val_o,
  output logic           wb_en_o,
  output logic           align_fault_o,
  output logic           illegal_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o       <= 1'b0;
      ea_o          <= '0;
      wb_val_o      <= '0;
      wb_en_o       <= 1'b0;
      align_fault_o <= 1'b0;
      illegal_o     <= 1'b0;
    end else begin
      valid_o       <= valid_c;
      wb_en_o       <= valid_c && wb_en_c;
      align_fault_o <= valid_c && fault_c;
      illegal_o     <= valid_c && illegal_c;
      if (valid_c) begin
        ea_o     <= ea_c;
        wb_val_o <= wb_c;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_c |=> valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_c |=> (!valid_o && !wb_en_o && !align_fault_o && !illegal_o));

  p_fault_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> !wb_en_o);

  p_wb_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> valid_o);

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int RW  = 32,
  parameter int EAW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic [2:0]     mode_i,
  input  logic [1:0]     size_i,
  input  logic           fetch_i,
  input  logic [RW-1:0]  areg_i,
  input  logic [RW-1:0]  absf_i,
  output logic           valid_o,
  output logic [EAW-1:0] ea_o,
  output logic [RW-1:0]  wb_val_o,
  output logic           wb_en_o,
  output logic           align_fault_o,
  output logic           illegal_o
);

  ea_mode_e       mode;
  ea_size_e       size;
  logic           step_sel;
  logic [EAW-1:0] step_addr;
  logic [RW-1:0]  step_wb;
  logic           misalign;
  logic           size_bad;
  logic           abs_sel;
  logic [RW-1:0]  abs_addr;
  logic           width_bad;
  logic           mode_bad;
  logic           illegal_c;
  logic           fault_c;
  logic           wb_en_c;
  logic [EAW-1:0] ea_c;
  logic [RW-1:0]  wb_c;

  assign mode = ea_mode_e'(mode_i);
  assign size = ea_size_e'(size_i);

  ea_step_path #(.RW(RW), .EAW(EAW)) u_step (
    .mode      (mode),
    .size      (size),
    .areg      (areg_i),
    .step_sel  (step_sel),
    .step_addr (step_addr),
    .step_wb   (step_wb),
    .misalign  (misalign),
    .size_bad  (size_bad)
  );

  ea_abs_path #(.RW(RW), .EAW(EAW)) u_abs (
    .mode      (mode),
    .fetch     (fetch_i),
    .field     (absf_i),
    .abs_sel   (abs_sel),
    .abs_addr  (abs_addr),
    .width_bad (width_bad)
  );

  assign mode_bad  = !step_sel && !abs_sel;
  assign illegal_c = mode_bad || size_bad || width_bad;
  assign fault_c   = misalign && !illegal_c;
  assign wb_en_c   = step_sel && !misalign && !illegal_c;

  always_comb begin
    ea_c = '0;
    wb_c = '0;
    if (!illegal_c) begin
      if (step_sel) begin
        ea_c = step_addr;
        wb_c = step_wb;
      end else begin
        ea_c = abs_addr[EAW-1:0];
      end
    end
  end

  ea_out_stage #(.RW(RW), .EAW(EAW)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_c       (valid_i),
    .ea_c          (ea_c),
    .wb_c          (wb_c),
    .wb_en_c       (wb_en_c),
    .fault_c       (fault_c),
    .illegal_c     (illegal_c),
    .valid_o       (valid_o),
    .ea_o          (ea_o),
    .wb_val_o      (wb_val_o),
    .wb_en_o       (wb_en_o),
    .align_fault_o (align_fault_o),
    .illegal_o     (illegal_o)
  );

  p_post_old_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 3'd0 && size_i != 2'd3) |=> (ea_o == $past(areg_i[EAW-1:0])));

  p_pre_same_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 3'd1 && size_i != 2'd3) |=> (ea_o == wb_val_o[EAW-1:0]));

  p_abs_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i >= 3'd2) |=> (!wb_en_o && wb_val_o == '0));

  p_abs8_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_sel && mode == EAM_ABS8) |-> (&abs_addr[RW-1:8]));

  p_abs8_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 3'd2 && !fetch_i) |=> (&ea_o[EAW-1:8]));

  p_abs24_zero_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_sel && mode == EAM_ABS24) |-> (abs_addr[RW-1:EAW] == '0));

  p_illegal_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!wb_en_o && !align_fault_o && ea_o == '0));

endmodule

// File: tb/tb_ea_gen_unit.sv
`timescale 1ns/1ps
module tb_ea_gen_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic        fetch_i = 1'b0;
  logic [31:0] areg_i = '0;
  logic [31:0] absf_i = '0;
  logic        valid_o;
  logic [23:0] ea_o;
  logic [31:0] wb_val_o;
  logic        wb_en_o;
  logic        align_fault_o;
  logic        illegal_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // expected output state
  logic        x_valid = 0;
  logic [23:0] x_ea = 0;
  logic [31:0] x_wb = 0;
  logic        x_we = 0;
  logic        x_flt = 0;
  logic        x_ill = 0;

  always #2 clk = ~clk;

  ea_gen_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .size_i(size_i), .fetch_i(fetch_i), .areg_i(areg_i), .absf_i(absf_i),
    .valid_o(valid_o), .ea_o(ea_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o),
    .align_fault_o(align_fault_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "valid_o", {31'b0, valid_o}, {31'b0, x_valid});
    chk(tag, "ea_o", {8'b0, ea_o}, {8'b0, x_ea});
    chk(tag, "wb_val_o", wb_val_o, x_wb);
    chk(tag, "wb_en_o", {31'b0, wb_en_o}, {31'b0, x_we});
    chk(tag, "align_fault_o", {31'b0, align_fault_o}, {31'b0, x_flt});
    chk(tag, "illegal_o", {31'b0, illegal_o}, {31'b0, x_ill});
  endtask

  // Behavioural restatement of the requirements.
  task automatic model(input logic [2:0] m, input logic [1:0] s, input logic f,
                       input logic [31:0] a, input logic [31:0] x);
    int stp;
    bit odd_multi;
    stp = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    odd_multi = (s == 2'd1 || s == 2'd2) && a[0];
    x_valid = 1; x_ea = 0; x_wb = 0; x_we = 0; x_flt = 0;
    x_ill = (m > 3'd5) || (m <= 3'd1 && s == 2'd3) ||
            (m == 3'd4 && !f) || ((m == 3'd2 || m == 3'd3 || m == 3'd5) && f);
    if (!x_ill) begin
      case (m)
        3'd0: begin x_ea = a[23:0]; x_wb = a + 32'(stp); x_flt = odd_multi; x_we = !odd_multi; end
        3'd1: begin x_wb = a - 32'(stp); x_ea = x_wb[23:0]; x_flt = odd_multi; x_we = !odd_multi; end
        3'd2: x_ea = 24'hFFFF00 + {16'h0, x[7:0]};
        3'd3: x_ea = x[15] ? (24'hFF0000 + {8'h0, x[15:0]}) : {8'h0, x[15:0]};
        default: x_ea = x[23:0];
      endcase
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] m, input logic [1:0] s,
                       input logic f, input logic [31:0] a, input logic [31:0] x,
                       input string tag);
    valid_i = v; mode_i = m; size_i = s; fetch_i = f; areg_i = a; absf_i = x;
    if (v) model(m, s, f, a, x);
    else begin x_valid = 0; x_we = 0; x_flt = 0; x_ill = 0; end
    @(negedge clk);
    chk_all(tag);
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic [1:0] s, input logic f);
    if (m > 3'd5 || (m <= 3'd1 && s == 2'd3) || (m == 3'd4 && !f) ||
        ((m == 3'd2 || m == 3'd3 || m == 3'd5) && f)) return "R12";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with active stimulus
    valid_i = 1; mode_i = 3'd0; size_i = 2'd2; areg_i = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk_all("R1");
    valid_i = 0;
    rst_n = 1;
    x_valid = 0;
    @(negedge clk);
    chk_all("R1");

    // R3 post-increment, R5 steps
    apply(1, 3'd0, 2'd0, 0, 32'h1234_5678, 32'h0, "R3");
    apply(1, 3'd0, 2'd1, 0, 32'h0000_1000, 32'h0, "R5");
    apply(1, 3'd0, 2'd2, 0, 32'h0000_1000, 32'h0, "R5");
    apply(1, 3'd0, 2'd2, 0, 32'hFFFF_FFFC, 32'h0, "R3");
    // R4 pre-decrement, wraparound
    apply(1, 3'd1, 2'd1, 0, 32'h0000_0100, 32'h0, "R4");
    apply(1, 3'd1, 2'd0, 0, 32'h0000_0000, 32'h0, "R4");
    apply(1, 3'd1, 2'd2, 0, 32'h0100_0002, 32'h0, "R4");
    // R6 alignment
    apply(1, 3'd0, 2'd1, 0, 32'h0000_0101, 32'h0, "R6");
    apply(1, 3'd1, 2'd2, 0, 32'h0000_0333, 32'h0, "R6");
    apply(1, 3'd0, 2'd0, 0, 32'h0000_0333, 32'h0, "R6");
    // R7 fetch flag ignored in stepping modes
    apply(1, 3'd0, 2'd1, 1, 32'h0000_2000, 32'h0, "R7");
    apply(1, 3'd1, 2'd0, 1, 32'h0000_2000, 32'h0, "R7");
    // R8 / R9 / R10 / R11 absolute forms
    apply(1, 3'd2, 2'd0, 0, 32'hDEAD_BEEF, 32'h1234_56AB, "R8");
    apply(1, 3'd2, 2'd2, 0, 32'h0, 32'h0000_0000, "R8");
    apply(1, 3'd3, 2'd1, 0, 32'h0, 32'hABCD_7FFF, "R9");
    apply(1, 3'd3, 2'd1, 0, 32'h0, 32'h0000_8000, "R9");
    apply(1, 3'd3, 2'd0, 0, 32'h0, 32'h0000_FFFF, "R9");
    apply(1, 3'd4, 2'd0, 1, 32'h0, 32'hAB12_3456, "R10");
    apply(1, 3'd5, 2'd2, 0, 32'h0, 32'h00FE_DCBA, "R11");
    apply(1, 3'd5, 2'd2, 0, 32'h0, 32'h7701_0203, "R11");
    // R12 illegal combinations
    apply(1, 3'd4, 2'd0, 0, 32'h0, 32'h0012_3456, "R12");
    apply(1, 3'd2, 2'd0, 1, 32'h0, 32'h0000_0012, "R12");
    apply(1, 3'd3, 2'd0, 1, 32'h0, 32'h0000_8000, "R12");
    apply(1, 3'd5, 2'd0, 1, 32'h0, 32'h0000_0040, "R12");
    apply(1, 3'd6, 2'd0, 0, 32'h0000_0010, 32'h0, "R12");
    apply(1, 3'd7, 2'd1, 0, 32'h0000_0010, 32'h0, "R12");
    apply(1, 3'd0, 2'd3, 0, 32'h0000_0011, 32'h0, "R12");
    // R2 idle hold after a result with write-back
    apply(1, 3'd0, 2'd2, 0, 32'h0000_4000, 32'h0, "R2");
    apply(0, 3'd1, 2'd0, 0, 32'h5555_5555, 32'hFFFF_FFFF, "R2");
    apply(0, 3'd2, 2'd1, 1, 32'h0, 32'h0, "R2");

    // mixed stimulus, checked every cycle
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      logic [1:0] s;
      logic f, v;
      m = 3'($urandom_range(0, 7));
      s = 2'($urandom_range(0, 3));
      f = 1'($urandom_range(0, 1));
      v = ($urandom_range(0, 7) != 0);
      apply(v, m, s, f, $urandom, $urandom, v ? tag_of(m, s, f) : "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule